// File: doc/BRIEF.md
# Descriptor Ring Commit Engine

The engine turns one transaction, a burst of one or more buffer segments, into consecutive 16-byte descriptors in a circular ring memory. Each segment carries a 64-bit buffer address, a 16-bit byte length, a flag that marks it as an immediate command, and the command's opcode. The engine formats each descriptor as it arrives. It writes the descriptor through a registered ring write port into the slot given by the free-running producer index plus the segment's position in the transaction. The slot number wraps silently past the last ring entry.

When the segment marked last has been written, the engine publishes the transaction. The producer index advances by the number of segments. On outbound rings it snapshots the running transaction and byte totals and then adds this commit to them. Finally it decides whether to pulse the doorbell: it does so when the caller asked for one, or when the free-entry count supplied by the reservation logic has fallen to zero.

The controller has four states. In S_IDLE the engine waits for the first segment. S_FILL collects further segments. S_PUBLISH advances the index and statistics, and S_RING is the one-cycle doorbell decision. The transitions are:
- take_first: S_IDLE to S_FILL.
- take_only: S_IDLE to S_PUBLISH, for a single-segment transaction.
- take_last: S_FILL to S_PUBLISH.
- publish_done: S_PUBLISH to S_RING.
- ring_done: S_RING to S_IDLE.

The segment input is ready only in S_IDLE and S_FILL.

Top module: `ring_commit_engine`

## Requirements
- R1: The descriptor written on `rw_data` carries the address in bits 63:0, the length-or-opcode field in bits 79:64, zeros in bits 95:80 and the flags word in bits 127:96.
- R2: The flags word's type field (flags bits 23:16) is 0x02 for a data segment and 0x03 for a command segment. The length-or-opcode field holds `seg_len` for data and `seg_opcode` for a command.
- R3: Every descriptor except the last of a transaction has the chain bit (flags bit 0) set, and flags bits 8, 9 and 10 clear.
- R4: The last descriptor of a transaction has the end-of-transfer interrupt bit (flags bit 9) set, and flags bits 0 and 8 clear. Its block-event bit (flags bit 10) equals `dir_outbound`.
- R5: Segment k (counted from 0) of a transaction is written to slot (`prod_idx` + k) mod RING_DEPTH, one cycle after it is accepted. A transaction that crosses the ring end continues at slot 0.
- R6: `prod_idx` is 0 after reset. It is unchanged in the cycle after the last segment is accepted. It has advanced by the transaction's segment count in the cycle where `commit_done` is high, and it changes at no other time.
- R7: `doorbell` is high only in the `commit_done` cycle. In that cycle it is high exactly when `seg_ring_db` was high with the last segment, or `free_left` is zero.
- R8: On an outbound commit, `rec_txn_cnt` and `rec_byte_cnt` show, in the `commit_done` cycle, the commit count and byte total as they stood before this commit, and `rec_txn_bytes` shows this commit's byte sum. An inbound commit leaves all totals and recorded values unchanged.
- R9: `seg_ready` is high in idle and while segments are collected. It is low for exactly the two cycles after the last segment is accepted.
- R10: After reset, `seg_ready` is high, and `rw_en`, `commit_done`, `doorbell` and all recorded statistics are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 64 | Buffer address |
| seg_len | input | 16 | Buffer length in bytes |
| seg_is_cmd | input | 1 | Segment is an immediate command |
| seg_opcode | input | 16 | Command opcode |
| seg_last | input | 1 | Final segment of the transaction |
| seg_ring_db | input | 1 | Doorbell requested (sampled with last segment) |
| dir_outbound | input | 1 | Ring runs toward the device |
| free_left | input | IDX_W | Free ring entries after reservation |
| rw_en | output | 1 | Ring write strobe |
| rw_slot | output | SLOT_W | Ring slot written |
| rw_data | output | 128 | Descriptor written |
| prod_idx | output | IDX_W | Free-running producer index |
| commit_done | output | 1 | One-cycle commit completion |
| doorbell | output | 1 | Doorbell pulse |
| rec_txn_cnt | output | TXN_W | Outbound commits before this one |
| rec_byte_cnt | output | BYTE_W | Outbound bytes before this one |
| rec_txn_bytes | output | SUM_W | Byte sum of this commit |

## Verification
Two decisions can fall in the same `commit_done` cycle: the forced doorbell for an exhausted ring and the publishing of the index and statistics. The bench provokes this overlap with a wrapping outbound commit that has no doorbell request and `free_left` at zero. It expects a doorbell pulse together with the wrapped index and the pre-commit totals. A second overlap is the last-entry flag choice and the slot wrap, which land on the same descriptor. The bench judges it by comparing that descriptor, written to slot 1 after slots 14, 15 and 0, against a descriptor it builds itself.

// File: rtl/ring_commit_pkg.sv
package ring_commit_pkg;

    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 16;
    localparam int ENTRY_W  = 128;

    // flag bit positions inside the 32-bit flags word
    localparam int FLAG_CHAIN = 0;
    localparam int FLAG_EOB   = 8;
    localparam int FLAG_EOT   = 9;
    localparam int FLAG_BEI   = 10;
    localparam int TYPE_LSB   = 16;

    localparam logic [7:0] KIND_DATA = 8'h02;
    localparam logic [7:0] KIND_CMD  = 8'h03;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_FILL    = 2'd1,
        S_PUBLISH = 2'd2,
        S_RING    = 2'd3
    } commit_state_e;

    typedef struct packed {
        logic [31:0]       flags;
        logic [15:0]       rsvd;
        logic [LEN_W-1:0]  len_op;
        logic [ADDR_W-1:0] addr;
    } ring_desc_t;

endpackage

// File: rtl/rce_desc_format.sv
module rce_desc_format
    import ring_commit_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              is_cmd,
    input  logic [LEN_W-1:0]  opcode,
    input  logic              last,
    input  logic              outbound,
    output ring_desc_t        desc
);

    logic [31:0] flags_w;

    always_comb begin
        flags_w = '0;
        flags_w[TYPE_LSB +: 8] = is_cmd ? KIND_CMD : KIND_DATA;
        if (last) begin
            flags_w[FLAG_EOT] = 1'b1;
            flags_w[FLAG_BEI] = outbound;
        end else begin
            flags_w[FLAG_CHAIN] = 1'b1;
        end
    end

    always_comb begin
        desc.addr   = addr;
        desc.len_op = is_cmd ? opcode : len;
        desc.rsvd   = '0;
        desc.flags  = flags_w;
    end

endmodule

// File: rtl/rce_slot_ptr.sv
module rce_slot_ptr #(
    parameter int RING_DEPTH = 16,
    parameter int IDX_W      = 16,
    parameter int MAX_SEGS   = 16,
    parameter int SLOT_W     = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_take,
    input  logic              advance,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [SLOT_W-1:0] wr_slot
);

    localparam int OFF_W = $clog2(MAX_SEGS + 1);

    logic [IDX_W-1:0] prod_q;
    logic [OFF_W-1:0] off_q;
    logic [IDX_W-1:0] wr_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            off_q  <= '0;
        end else if (advance) begin
            prod_q <= prod_q + IDX_W'(off_q);
            off_q  <= '0;
        end else if (seg_take) begin
            off_q  <= off_q + 1'b1;
        end
    end

    // power-of-two depth: slot is the low bits of index plus offset
    assign wr_sum   = prod_q + IDX_W'(off_q);
    assign wr_slot  = wr_sum[SLOT_W-1:0];
    assign prod_idx = prod_q;

    // R5
    off_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(off_q) <= MAX_SEGS);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && off_q != '0) |=> (prod_q != $past(prod_q)));

endmodule

// File: rtl/rce_tx_stats.sv
module rce_tx_stats #(
    parameter int STATS_EN = 1,
    parameter int TXN_W    = 32,
    parameter int BYTE_W   = 48,
    parameter int LEN_W    = 16,
    parameter int SUM_W    = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_take,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              publish,
    input  logic              outbound,
    output logic [TXN_W-1:0]  rec_txn_cnt,
    output logic [BYTE_W-1:0] rec_byte_cnt,
    output logic [SUM_W-1:0]  rec_txn_bytes
);

    generate
        if (STATS_EN != 0) begin : g_stats
            logic [TXN_W-1:0]  txn_q;
            logic [BYTE_W-1:0] byte_q;
            logic [SUM_W-1:0]  sum_q;
            logic [TXN_W-1:0]  rec_txn_q;
            logic [BYTE_W-1:0] rec_byte_q;
            logic [SUM_W-1:0]  rec_sum_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    txn_q      <= '0;
                    byte_q     <= '0;
                    sum_q      <= '0;
                    rec_txn_q  <= '0;
                    rec_byte_q <= '0;
                    rec_sum_q  <= '0;
                end else if (publish) begin
                    if (outbound) begin
                        rec_txn_q  <= txn_q;
                        rec_byte_q <= byte_q;
                        rec_sum_q  <= sum_q;
                        txn_q      <= txn_q + 1'b1;
                        byte_q     <= byte_q + BYTE_W'(sum_q);
                    end
                    sum_q <= '0;
                end else if (seg_take) begin
                    sum_q <= sum_q + SUM_W'(seg_len);
                end
            end

            assign rec_txn_cnt   = rec_txn_q;
            assign rec_byte_cnt  = rec_byte_q;
            assign rec_txn_bytes = rec_sum_q;

            // R8
            inbound_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (publish && !outbound) |=> (rec_txn_cnt == $past(rec_txn_cnt)
                                            && rec_byte_cnt == $past(rec_byte_cnt)));

            // R8
            outbound_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (publish && outbound) |=> (txn_q == rec_txn_cnt + 1'b1));
        end else begin : g_nostats
            assign rec_txn_cnt   = '0;
            assign rec_byte_cnt  = '0;
            assign rec_txn_bytes = '0;
        end
    endgenerate

endmodule

// File: rtl/ring_commit_engine.sv
module ring_commit_engine
    import ring_commit_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    parameter int IDX_W      = 16,
    parameter int MAX_SEGS   = 16,
    parameter int TXN_W      = 32,
    parameter int BYTE_W     = 48,
    parameter int STATS_EN   = 1,
    parameter int SLOT_W     = $clog2(RING_DEPTH),
    parameter int SUM_W      = 16 + $clog2(MAX_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [63:0]       seg_addr,
    input  logic [15:0]       seg_len,
    input  logic              seg_is_cmd,
    input  logic [15:0]       seg_opcode,
    input  logic              seg_last,
    input  logic              seg_ring_db,
    input  logic              dir_outbound,
    input  logic [IDX_W-1:0]  free_left,
    output logic              rw_en,
    output logic [SLOT_W-1:0] rw_slot,
    output logic [127:0]      rw_data,
    output logic [IDX_W-1:0]  prod_idx,
    output logic              commit_done,
    output logic              doorbell,
    output logic [TXN_W-1:0]  rec_txn_cnt,
    output logic [BYTE_W-1:0] rec_byte_cnt,
    output logic [SUM_W-1:0]  rec_txn_bytes
);

    commit_state_e state_q, state_d;
    logic          seg_take;
    logic          publish;
    logic          db_req_q;
    logic [SLOT_W-1:0] wr_slot;
    ring_desc_t    fmt_desc;

    assign seg_take = seg_valid && seg_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (seg_take) state_d = seg_last ? S_PUBLISH : S_FILL;
            S_FILL:    if (seg_take && seg_last) state_d = S_PUBLISH;
            S_PUBLISH: state_d = S_RING;
            S_RING:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        seg_ready   = 1'b0;
        publish     = 1'b0;
        commit_done = 1'b0;
        doorbell    = 1'b0;
        unique case (state_q)
            S_IDLE, S_FILL: seg_ready = 1'b1;
            S_PUBLISH:      publish   = 1'b1;
            S_RING: begin
                commit_done = 1'b1;
                doorbell    = db_req_q || (free_left == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    db_req_q <= 1'b0;
        else if (seg_take && seg_last) db_req_q <= seg_ring_db;
    end

    rce_desc_format u_fmt (
        .addr     (seg_addr),
        .len      (seg_len),
        .is_cmd   (seg_is_cmd),
        .opcode   (seg_opcode),
        .last     (seg_last),
        .outbound (dir_outbound),
        .desc     (fmt_desc)
    );

    rce_slot_ptr #(
        .RING_DEPTH (RING_DEPTH),
        .IDX_W      (IDX_W),
        .MAX_SEGS   (MAX_SEGS),
        .SLOT_W     (SLOT_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_take (seg_take),
        .advance  (publish),
        .prod_idx (prod_idx),
        .wr_slot  (wr_slot)
    );

    rce_tx_stats #(
        .STATS_EN (STATS_EN),
        .TXN_W    (TXN_W),
        .BYTE_W   (BYTE_W),
        .LEN_W    (LEN_W),
        .SUM_W    (SUM_W)
    ) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .seg_take      (seg_take),
        .seg_len       (seg_len),
        .publish       (publish),
        .outbound      (dir_outbound),
        .rec_txn_cnt   (rec_txn_cnt),
        .rec_byte_cnt  (rec_byte_cnt),
        .rec_txn_bytes (rec_txn_bytes)
    );

    // registered ring write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_en   <= 1'b0;
            rw_slot <= '0;
            rw_data <= '0;
        end else begin
            rw_en <= seg_take;
            if (seg_take) begin
                rw_slot <= wr_slot;
                rw_data <= fmt_desc;
            end
        end
    end

    // R3
    mid_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_take && !seg_last) |=> (rw_en && rw_data[96 + FLAG_CHAIN]
                                     && !rw_data[96 + FLAG_EOT]));

    // R4
    last_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_take && seg_last) |=> (rw_en && rw_data[96 + FLAG_EOT]
                                    && !rw_data[96 + FLAG_CHAIN]));

    // R9
    busy_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_take && seg_last) |=> !seg_ready);

    // R6
    idx_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idx != $past(prod_idx)) |-> commit_done);

    // R7
    db_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |-> commit_done);

endmodule

// File: tb/ring_commit_engine_tb_top.sv
`timescale 1ns/1ps
module ring_commit_engine_tb_top;

    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seg_valid = 1'b0;
    logic         seg_ready;
    logic [63:0]  seg_addr = '0;
    logic [15:0]  seg_len = '0;
    logic         seg_is_cmd = 1'b0;
    logic [15:0]  seg_opcode = '0;
    logic         seg_last = 1'b0;
    logic         seg_ring_db = 1'b0;
    logic         dir_outbound = 1'b0;
    logic [15:0]  free_left = 16'd8;
    logic         rw_en;
    logic [3:0]   rw_slot;
    logic [127:0] rw_data;
    logic [15:0]  prod_idx;
    logic         commit_done;
    logic         doorbell;
    logic [31:0]  rec_txn_cnt;
    logic [47:0]  rec_byte_cnt;
    logic [20:0]  rec_txn_bytes;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [63:0]  s_addr [16];
    logic [15:0]  s_len  [16];
    logic         s_cmd  [16];
    logic [15:0]  s_op   [16];

    logic [3:0]   cap_slot [64];
    logic [127:0] cap_data [64];
    int           cap_n = 0;

    always #2.5 clk = ~clk;

    ring_commit_engine dut_i (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_is_cmd(seg_is_cmd),
        .seg_opcode(seg_opcode), .seg_last(seg_last), .seg_ring_db(seg_ring_db),
        .dir_outbound(dir_outbound), .free_left(free_left), .rw_en(rw_en),
        .rw_slot(rw_slot), .rw_data(rw_data), .prod_idx(prod_idx),
        .commit_done(commit_done), .doorbell(doorbell), .rec_txn_cnt(rec_txn_cnt),
        .rec_byte_cnt(rec_byte_cnt), .rec_txn_bytes(rec_txn_bytes)
    );

    always @(posedge clk) begin
        if (rw_en && cap_n < 64) begin
            cap_slot[cap_n] <= rw_slot;
            cap_data[cap_n] <= rw_data;
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_desc(input logic [63:0] a, input logic [15:0] l,
                                             input logic c, input logic [15:0] op,
                                             input logic last, input logic outb);
        logic [31:0] f;
        f = 32'h0;
        f[23:16] = c ? 8'h03 : 8'h02;
        if (last) begin
            f[9]  = 1'b1;
            f[10] = outb;
        end else begin
            f[0] = 1'b1;
        end
        return {f, 16'h0000, (c ? op : l), a};
    endfunction

    // drives n segments, then checks descriptors, index, doorbell and stats
    task automatic run_commit(input int n, input bit outb, input bit db, input int freel,
                              input bit exp_db, input longint exp_txn, input longint exp_bytes,
                              input longint exp_sum, input string tag);
        int base_cap;
        int start_idx;
        base_cap  = cap_n;
        start_idx = int'(prod_idx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(seg_ready == 1'b1, "R9", {tag, " ready while collecting"}, 128'(seg_ready), 128'd1);
            dir_outbound = outb;
            free_left    = 16'(freel);
            seg_valid    = 1'b1;
            seg_addr     = s_addr[i];
            seg_len      = s_len[i];
            seg_is_cmd   = s_cmd[i];
            seg_opcode   = s_op[i];
            seg_last     = (i == n - 1);
            seg_ring_db  = (i == n - 1) ? db : 1'b0;
        end
        @(negedge clk);
        seg_valid = 1'b0;
        seg_last  = 1'b0;
        chk(seg_ready == 1'b0, "R9", {tag, " busy after last"}, 128'(seg_ready), 128'd0);
        chk(int'(prod_idx) == start_idx, "R6", {tag, " index held before done"},
            128'(prod_idx), 128'(start_idx));
        chk(commit_done == 1'b0, "R6", {tag, " no early done"}, 128'(commit_done), 128'd0);
        @(negedge clk);
        chk(commit_done == 1'b1, "R6", {tag, " done pulse"}, 128'(commit_done), 128'd1);
        chk(seg_ready == 1'b0, "R9", {tag, " busy in done cycle"}, 128'(seg_ready), 128'd0);
        chk(int'(prod_idx) == ((start_idx + n) & 16'hFFFF), "R6", {tag, " index advanced"},
            128'(prod_idx), 128'(start_idx + n));
        chk(doorbell == exp_db, "R7", {tag, " doorbell"}, 128'(doorbell), 128'(exp_db));
        chk(64'(rec_txn_cnt) == exp_txn, "R8", {tag, " recorded count"},
            128'(rec_txn_cnt), 128'(exp_txn));
        chk(64'(rec_byte_cnt) == exp_bytes, "R8", {tag, " recorded bytes"},
            128'(rec_byte_cnt), 128'(exp_bytes));
        if (outb)
            chk(64'(rec_txn_bytes) == exp_sum, "R8", {tag, " commit bytes"},
                128'(rec_txn_bytes), 128'(exp_sum));
        chk(cap_n - base_cap == n, "R5", {tag, " write count"}, 128'(cap_n - base_cap), 128'(n));
        for (int i = 0; i < n; i++) begin
            logic [127:0] e;
            e = mk_desc(s_addr[i], s_len[i], s_cmd[i], s_op[i], i == n - 1, outb);
            chk(int'(cap_slot[base_cap + i]) == ((start_idx + i) % DEPTH), "R5",
                {tag, " slot"}, 128'(cap_slot[base_cap + i]), 128'((start_idx + i) % DEPTH));
            chk(cap_data[base_cap + i] == e, (i == n - 1) ? "R4" : "R3",
                {tag, " descriptor (R1 R2 layout)"}, cap_data[base_cap + i], e);
        end
        @(negedge clk);
        chk(seg_ready == 1'b1, "R9", {tag, " ready after done"}, 128'(seg_ready), 128'd1);
        chk(doorbell == 1'b0, "R7", {tag, " doorbell one cycle"}, 128'(doorbell), 128'd0);
    endtask

    // R10
    task automatic t_reset();
        @(negedge clk);
        chk(seg_ready == 1'b1, "R10", "ready after reset", 128'(seg_ready), 128'd1);
        chk(rw_en == 1'b0, "R10", "no write after reset", 128'(rw_en), 128'd0);
        chk(prod_idx == 16'd0, "R10", "index zero", 128'(prod_idx), 128'd0);
        chk(commit_done == 1'b0 && doorbell == 1'b0, "R10", "no done or doorbell",
            128'({commit_done, doorbell}), 128'd0);
        chk(rec_txn_cnt == 0 && rec_byte_cnt == 0 && rec_txn_bytes == 0, "R10", "stats zero",
            128'(rec_byte_cnt), 128'd0);
    endtask

    // R2 R4 R7: single inbound data segment with doorbell request, no block-event bit
    task automatic t_single_inbound();
        s_addr[0] = 64'h1000_0000_0000_0040; s_len[0] = 16'h0100; s_cmd[0] = 0; s_op[0] = 16'h00AA;
        run_commit(1, 0, 1, 10, 1, 0, 0, 0, "single inbound");
    endtask

    // R2 R3 R4 R8: outbound mixed data and command, no doorbell
    task automatic t_mixed_outbound();
        s_addr[0] = 64'hAAAA_0000_0000_1000; s_len[0] = 16'h0020; s_cmd[0] = 0; s_op[0] = 16'h0007;
        s_addr[1] = 64'hBBBB_0000_0000_2000; s_len[1] = 16'h0040; s_cmd[1] = 1; s_op[1] = 16'h0005;
        s_addr[2] = 64'hCCCC_0000_0000_3000; s_len[2] = 16'h0080; s_cmd[2] = 0; s_op[2] = 16'h0009;
        run_commit(3, 1, 0, 3, 0, 0, 0, 64'hE0, "mixed outbound");
    endtask

    // R5 R7 R8: long commit, then a wrapping commit with free count zero forcing doorbell
    task automatic t_wrap_forced();
        for (int i = 0; i < 10; i++) begin
            s_addr[i] = 64'h5000_0000_0000_0000 + 64'(i * 64); s_len[i] = 16'h0010;
            s_cmd[i] = 0; s_op[i] = 16'h0;
        end
        run_commit(10, 1, 1, 8, 1, 1, 64'hE0, 64'hA0, "long outbound");
        for (int i = 0; i < 4; i++) begin
            s_addr[i] = 64'h6000_0000_0000_0000 + 64'(i); s_len[i] = 16'h0010;
            s_cmd[i] = (i == 3); s_op[i] = 16'h0033;
        end
        run_commit(4, 1, 0, 0, 1, 2, 64'h180, 64'h40, "wrap forced doorbell");
    endtask

    // R8: inbound commit leaves totals, next outbound sees them untouched
    task automatic t_inbound_no_stats();
        s_addr[0] = 64'h7000_0000_0000_0000; s_len[0] = 16'h0300; s_cmd[0] = 0; s_op[0] = 0;
        s_addr[1] = 64'h7000_0000_0000_1000; s_len[1] = 16'h0200; s_cmd[1] = 0; s_op[1] = 0;
        run_commit(2, 0, 0, 4, 0, 2, 64'h180, 0, "inbound keeps totals");
        s_addr[0] = 64'h8000_0000_0000_0000; s_len[0] = 16'h0008; s_cmd[0] = 0; s_op[0] = 0;
        run_commit(1, 1, 0, 2, 0, 3, 64'h1C0, 64'h8, "outbound after inbound");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_inbound();
        t_mixed_outbound();
        t_wrap_forced();
        t_inbound_no_stats();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule